// File: doc/BRIEF.md
# Switch Polling Sequencer with Wetting-Current Diagnostics

This block steps through eight switch inputs, one at a time and always in ascending order, once per polling sequence. Each input that is enabled for polling has its wetting-current enable switched on for a fixed window. Inputs 0 to 3 can also be checked for a healthy wetting current. Inputs 0 and 1 check a current source, and inputs 2 and 3 check a current sink. For a checked input, the current window is extended by one ADC conversion time. An ADC sample strobe fires on the last cycle of that extension, and at that moment the block samples a one-bit health verdict from the analog side.

A failed check sets a per-input fault bit and a summary interrupt bit. It also pulls an active-low interrupt line low and raises the status flag used in the serial status byte. A status read clears all of these. A sequence runs once per start pulse. In auto-repeat mode it restarts by itself after an idle gap, and the diagnostics run in both modes.

The controller is a five-state machine:
- ST_WAIT: idle until start_i.
- ST_SCAN: one cycle per input slot. It decides between polling that input, skipping it, or ending the sequence.
- ST_ACT: the poll-active window.
- ST_CONV: the diagnostic extension with the ADC strobe.
- ST_REST: the idle gap between auto-repeated sequences.

The transitions are:
- WAIT→SCAN on start.
- SCAN→ACT if the input is enabled.
- SCAN→SCAN to skip to the next slot.
- SCAN/ACT/CONV→REST or WAIT after the last slot, depending on auto-repeat.
- ACT→CONV if the input is diagnosable.
- ACT/CONV→SCAN to advance to the next slot.
- REST→SCAN or WAIT when the gap expires.

Top module: `sw_poll_seq`

## Requirements
- R1: After reset, all current enables, the ADC strobe, the fault bits, the summary flag and the status flag are 0, and int_n_o is 1.
- R2: Within a sequence, inputs are served in ascending index order, and at most one bit of wet_en_o is high in any cycle.
- R3: An input whose poll_en_i bit is 0 gets no current window, no ADC strobe and no fault bit, even if its diag_en_i bit is 1.
- R4: An enabled input that is not diagnosable holds its wet_en_o bit high for exactly ACT_CYC consecutive cycles, once per sequence.
- R5: An input is diagnosable when all of the following hold: its index is 0..3, poll_en_i is 1, diag_en_i is 1, adc_mode_i is 1, and src_dir_i equals 1 on inputs 0 and 1 (source) or 0 on inputs 2 and 3 (sink). A diagnosable input holds wet_en_o high for ACT_CYC+ADC_CYC consecutive cycles.
- R6: adc_smp_o pulses exactly once per diagnosable input, on the last cycle of its window. A wrong mode or a wrong direction suppresses the strobe and the extension.
- R7: If health_ok_i is 0 in the strobe cycle of input i, diag_fail_o bit i is set from the next cycle onward. With health_ok_i at 1, the bit stays 0.
- R8: Whenever any fault bit is set, wet_diag_irq_o and oi_flag_o are 1 and int_n_o is 0.
- R9: With auto_rpt_i at 1, the next sequence starts on its own. Exactly IDLE_CYC+1 cycles with no current enable separate the last input's window from input 0's next window, and diagnostics run on every sequence. With auto_rpt_i at 0, polling stops after the current sequence.
- R10: A cycle with stat_rd_i at 1 and no fault arriving clears all fault bits and the summary flag, and int_n_o returns to 1 on the next cycle.
- R11: A fault that arrives in the same cycle as stat_rd_i stays latched, along with the summary flag, while the older fault bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en_i | input | N_IN | Per-input polling enable |
| diag_en_i | input | N_DIAG | Per-input diagnostic enable, inputs 0..3 |
| src_dir_i | input | N_DIAG | Current direction, 1 = source, 0 = sink |
| adc_mode_i | input | N_DIAG | 1 = input is in ADC mode |
| start_i | input | 1 | Starts a sequence from ST_WAIT |
| auto_rpt_i | input | 1 | Restarts after the idle gap when 1 |
| health_ok_i | input | 1 | Sampled health verdict, 1 = healthy |
| stat_rd_i | input | 1 | Interrupt status read, clears the flags |
| wet_en_o | output | N_IN | Per-input wetting-current enable |
| adc_smp_o | output | 1 | ADC sample strobe |
| diag_fail_o | output | N_DIAG | Per-input fault detail bits |
| wet_diag_irq_o | output | 1 | Summary diagnostic interrupt bit |
| int_n_o | output | 1 | Active-low interrupt line |
| oi_flag_o | output | 1 | Status flag for the serial status byte |

## Verification
The status read and the capture of a new fault can land on the same clock edge, and R11 decides which one wins. The bench provokes this collision by tying stat_rd_i to adc_smp_o, so the read hits exactly the cycle in which a failing verdict is sampled. An older fault on another input is left latched beforehand. The check then expects the new bit and the summary flag to survive and the old bit to be gone, while the rest of the run sweeps every combination of enable and diagnostic mask.

// File: rtl/sw_poll_pkg.sv
package sw_poll_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_SCAN,
        ST_ACT,
        ST_CONV,
        ST_REST
    } seq_state_e;
endpackage

// File: rtl/sw_poll_elig.sv
// Decides per input whether the wetting-current health check may run.
module sw_poll_elig #(
    parameter int N_IN   = 8,
    parameter int N_DIAG = 4
) (
    input  logic [N_IN-1:0]   poll_en_i,
    input  logic [N_DIAG-1:0] diag_en_i,
    input  logic [N_DIAG-1:0] src_dir_i,
    input  logic [N_DIAG-1:0] adc_mode_i,
    output logic [N_IN-1:0]   elig_o
);
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        if (i < N_DIAG) begin : g_diag
            // lower half checks a source, upper half a sink
            localparam logic WANT_SRC = (i < N_DIAG / 2);
            assign elig_o[i] = poll_en_i[i] & diag_en_i[i] & adc_mode_i[i]
                             & (src_dir_i[i] == WANT_SRC);
        end else begin : g_plain
            assign elig_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sw_poll_fsm.sv
// Polling walk: scan slots, active window, conversion extension, rest gap.
module sw_poll_fsm
    import sw_poll_pkg::*;
#(
    parameter int N_IN     = 8,
    parameter int ACT_CYC  = 4,
    parameter int ADC_CYC  = 3,
    parameter int IDLE_CYC = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      auto_rpt_i,
    input  logic [N_IN-1:0]           poll_en_i,
    input  logic [N_IN-1:0]           elig_i,
    output logic [N_IN-1:0]           wet_en_o,
    output logic                      adc_smp_o,
    output logic [$clog2(N_IN)-1:0]   idx_o
);
    localparam int IW      = $clog2(N_IN);
    localparam int MAX_AB  = (ACT_CYC > ADC_CYC) ? ACT_CYC : ADC_CYC;
    localparam int CNT_MAX = (MAX_AB > IDLE_CYC) ? MAX_AB : IDLE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          advance;
    logic          last_slot;

    assign last_slot = (idx_q == IW'(N_IN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        advance = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (start_i) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                end
            end
            ST_SCAN: begin
                if (poll_en_i[idx_q]) begin
                    state_d = ST_ACT;
                    cnt_d   = '0;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_ACT: begin
                if (cnt_q == CW'(ACT_CYC - 1)) begin
                    if (elig_i[idx_q]) begin
                        state_d = ST_CONV;
                        cnt_d   = '0;
                    end else begin
                        advance = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CONV: begin
                if (cnt_q == CW'(ADC_CYC - 1)) begin
                    advance = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REST: begin
                if (cnt_q == CW'(IDLE_CYC - 1)) begin
                    state_d = auto_rpt_i ? ST_SCAN : ST_WAIT;
                    idx_d   = '0;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_WAIT;
        endcase
        if (advance) begin
            cnt_d = '0;
            if (last_slot) begin
                state_d = auto_rpt_i ? ST_REST : ST_WAIT;
            end else begin
                state_d = ST_SCAN;
                idx_d   = idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wet_en_o  = '0;
        adc_smp_o = 1'b0;
        unique case (state_q)
            ST_ACT:  wet_en_o[idx_q] = 1'b1;
            ST_CONV: begin
                wet_en_o[idx_q] = 1'b1;
                adc_smp_o       = (cnt_q == CW'(ADC_CYC - 1));
            end
            default: ;
        endcase
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/sw_poll_fault.sv
// Latches health-check failures; a status read clears, a new fault wins.
module sw_poll_fault #(
    parameter int N_DIAG = 4,
    parameter int IW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic              ok_i,
    input  logic [IW-1:0]     idx_i,
    input  logic              rd_i,
    output logic [N_DIAG-1:0] fail_o,
    output logic              irq_o
);
    logic [N_DIAG-1:0] new_f;
    logic [N_DIAG-1:0] fail_q;
    logic              irq_q;

    for (genvar i = 0; i < N_DIAG; i++) begin : g_hit
        assign new_f[i] = smp_i & ~ok_i & (idx_i == IW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            fail_q <= (rd_i ? '0 : fail_q) | new_f;
            irq_q  <= (rd_i ? 1'b0 : irq_q) | (|new_f);
        end
    end

    assign fail_o = fail_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/sw_poll_seq.sv
module sw_poll_seq #(
    parameter int N_IN     = 8,
    parameter int N_DIAG   = 4,
    parameter int ACT_CYC  = 4,
    parameter int ADC_CYC  = 3,
    parameter int IDLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   poll_en_i,
    input  logic [N_DIAG-1:0] diag_en_i,
    input  logic [N_DIAG-1:0] src_dir_i,
    input  logic [N_DIAG-1:0] adc_mode_i,
    input  logic              start_i,
    input  logic              auto_rpt_i,
    input  logic              health_ok_i,
    input  logic              stat_rd_i,
    output logic [N_IN-1:0]   wet_en_o,
    output logic              adc_smp_o,
    output logic [N_DIAG-1:0] diag_fail_o,
    output logic              wet_diag_irq_o,
    output logic              int_n_o,
    output logic              oi_flag_o
);
    localparam int IW = $clog2(N_IN);

    logic [N_IN-1:0] elig;
    logic [IW-1:0]   cur_idx;
    logic            irq;

    sw_poll_elig #(.N_IN(N_IN), .N_DIAG(N_DIAG)) u_elig (
        .poll_en_i  (poll_en_i),
        .diag_en_i  (diag_en_i),
        .src_dir_i  (src_dir_i),
        .adc_mode_i (adc_mode_i),
        .elig_o     (elig)
    );

    sw_poll_fsm #(
        .N_IN(N_IN), .ACT_CYC(ACT_CYC), .ADC_CYC(ADC_CYC), .IDLE_CYC(IDLE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .auto_rpt_i (auto_rpt_i),
        .poll_en_i  (poll_en_i),
        .elig_i     (elig),
        .wet_en_o   (wet_en_o),
        .adc_smp_o  (adc_smp_o),
        .idx_o      (cur_idx)
    );

    sw_poll_fault #(.N_DIAG(N_DIAG), .IW(IW)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (adc_smp_o),
        .ok_i   (health_ok_i),
        .idx_i  (cur_idx),
        .rd_i   (stat_rd_i),
        .fail_o (diag_fail_o),
        .irq_o  (irq)
    );

    assign wet_diag_irq_o = irq;
    assign int_n_o        = ~irq;
    assign oi_flag_o      = irq;
endmodule

// File: rtl/sw_poll_seq_chk.sv
module sw_poll_seq_chk #(
    parameter int N_IN   = 8,
    parameter int N_DIAG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_IN-1:0]   wet_en_o,
    input logic              adc_smp_o,
    input logic              health_ok_i,
    input logic              stat_rd_i,
    input logic [N_DIAG-1:0] diag_fail_o,
    input logic              wet_diag_irq_o,
    input logic              int_n_o
);
    // R2
    wet_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wet_en_o));

    // R6
    adc_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_smp_o |-> (|wet_en_o[N_DIAG-1:0]));

    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(diag_fail_o & ~$past(diag_fail_o))) |-> $past(adc_smp_o && !health_ok_i));

    // R8
    irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wet_diag_irq_o == (|diag_fail_o));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !adc_smp_o) |=> (!wet_diag_irq_o && int_n_o));
endmodule

bind sw_poll_seq sw_poll_seq_chk #(.N_IN(N_IN), .N_DIAG(N_DIAG)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wet_en_o       (wet_en_o),
    .adc_smp_o      (adc_smp_o),
    .health_ok_i    (health_ok_i),
    .stat_rd_i      (stat_rd_i),
    .diag_fail_o    (diag_fail_o),
    .wet_diag_irq_o (wet_diag_irq_o),
    .int_n_o        (int_n_o)
);

// File: tb/sw_poll_seq_bench.sv
`timescale 1ns/1ps
module sw_poll_seq_bench;
    localparam int CLK_PER = 10;
    localparam int ACT     = 4;
    localparam int ADC     = 3;
    localparam int IDLE    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] poll_en = '0;
    logic [3:0] diag_en = '0, src_dir = 4'b0011, adc_mode = 4'hF;
    logic       start = 1'b0, auto_rpt = 1'b0;
    logic       health_ok, stat_rd;
    logic       rd_man = 1'b0, rd_on_smp = 1'b0;
    logic [3:0] bad_mask = '0;
    logic [7:0] wet_en;
    logic       adc_smp;
    logic [3:0] diag_fail;
    logic       irq, int_n, oi_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER / 2) clk = ~clk;

    assign health_ok = ~|(wet_en[3:0] & bad_mask);
    assign stat_rd   = rd_man | (rd_on_smp & adc_smp);

    sw_poll_seq #(.N_IN(8), .N_DIAG(4), .ACT_CYC(ACT), .ADC_CYC(ADC), .IDLE_CYC(IDLE))
    u_sw_poll_seq (
        .clk(clk), .rst_n(rst_n), .poll_en_i(poll_en), .diag_en_i(diag_en),
        .src_dir_i(src_dir), .adc_mode_i(adc_mode), .start_i(start),
        .auto_rpt_i(auto_rpt), .health_ok_i(health_ok), .stat_rd_i(stat_rd),
        .wet_en_o(wet_en), .adc_smp_o(adc_smp), .diag_fail_o(diag_fail),
        .wet_diag_irq_o(irq), .int_n_o(int_n), .oi_flag_o(oi_flag)
    );

    // monitor
    logic       mon_clr = 1'b0;
    logic [7:0] prev_wet;
    int wcnt [8];
    int rises [8];
    int adc_n, multi, last_idx, order_bad, gap_cnt, gap_meas;
    logic in_gap;

    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < 8; i++) begin wcnt[i] = 0; rises[i] = 0; end
            adc_n = 0; multi = 0; last_idx = -1; order_bad = 0;
            gap_cnt = 0; gap_meas = -1; in_gap = 1'b0; prev_wet = '0;
        end else begin
            if ($countones(wet_en) > 1) multi++;
            if (adc_smp) adc_n++;
            for (int i = 0; i < 8; i++) begin
                if (wet_en[i]) wcnt[i]++;
                if (wet_en[i] && !prev_wet[i]) begin
                    rises[i]++;
                    if (i <= last_idx) order_bad = 1;
                    last_idx = i;
                end
            end
            if (wet_en[7]) begin
                in_gap = 1'b1; gap_cnt = 0;
            end else if (in_gap && wet_en == '0) begin
                gap_cnt++;
            end else if (in_gap && wet_en[0]) begin
                gap_meas = gap_cnt; in_gap = 1'b0;
            end
            prev_wet = wet_en;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] elig_f(logic [7:0] pe, logic [3:0] de,
                                          logic [3:0] am, logic [3:0] sd);
        logic [3:0] e;
        for (int i = 0; i < 4; i++)
            e[i] = pe[i] & de[i] & am[i] & (sd[i] == (i < 2));
        return e;
    endfunction

    task automatic clear_and_check();
        @(posedge clk); #1; rd_man = 1'b1; mon_clr = 1'b1;
        @(posedge clk); #1; rd_man = 1'b0; mon_clr = 1'b0;
        @(negedge clk);
        // R10: read clears everything
        chk(diag_fail == 0 && !irq && int_n && !oi_flag, "R10", "cleared flags",
            {diag_fail, irq, int_n}, 1);
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic run_seq(input logic [7:0] pe, input logic [3:0] de,
                           input logic [3:0] am, input logic [3:0] sd,
                           input logic [3:0] bad);
        logic [3:0] el;
        logic [3:0] expf;
        int ew;
        @(posedge clk); #1;
        poll_en = pe; diag_en = de; adc_mode = am; src_dir = sd; bad_mask = bad;
        clear_and_check();
        pulse_start();
        repeat (90) @(posedge clk);
        @(negedge clk);
        el   = elig_f(pe, de, am, sd);
        expf = el & bad;
        for (int i = 0; i < 8; i++) begin
            ew = !pe[i] ? 0 : ((i < 4 && el[i]) ? ACT + ADC : ACT);
            if (!pe[i])
                chk(wcnt[i] == 0 && rises[i] == 0, "R3", "disabled window", wcnt[i], 0);
            else if (i < 4 && el[i])
                chk(wcnt[i] == ew && rises[i] == 1, "R5", "diag window", wcnt[i], ew);
            else
                chk(wcnt[i] == ew && rises[i] == 1, "R4", "plain window", wcnt[i], ew);
        end
        // R2: order and exclusivity
        chk(multi == 0 && order_bad == 0, "R2", "order/onehot", multi + order_bad, 0);
        // R6: one strobe per diagnosable input
        chk(adc_n == $countones(el), "R6", "adc strobes", adc_n, $countones(el));
        // R7: detail bits
        chk(diag_fail == expf, "R7", "fault bits", diag_fail, expf);
        // R8: summary, line and flag
        chk(irq == (expf != 0) && int_n == (expf == 0) && oi_flag == (expf != 0),
            "R8", "summary flags", {irq, int_n, oi_flag}, (expf != 0) ? 3'b101 : 3'b010);
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r0;
        mon_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(wet_en == 0 && !adc_smp && diag_fail == 0 && !irq && int_n && !oi_flag,
            "R1", "reset outputs", {wet_en, adc_smp, diag_fail, irq, int_n}, 1);
        @(posedge clk); #1; rst_n = 1'b1; mon_clr = 1'b0;

        // full sweep of diag enable x low enable nibble, correct configuration
        for (int de = 0; de < 16; de++)
            for (int pl = 0; pl < 16; pl++)
                run_seq({4'(de ^ pl), 4'(pl)}, 4'(de), 4'hF, 4'b0011, 4'(de + pl));

        // misconfiguration sweeps: mode bits, then direction bits (R6)
        for (int m = 0; m < 16; m++)
            run_seq(8'hFF, 4'hF, 4'(m), 4'b0011, 4'hF);
        for (int m = 0; m < 16; m++)
            run_seq(8'hFF, 4'hF, 4'hF, 4'(m), 4'hF);

        // R11: fault coinciding with a status read
        run_seq(8'h0F, 4'b0100, 4'hF, 4'b0011, 4'b0100);
        @(posedge clk); #1; diag_en = 4'b0001; bad_mask = 4'b0001; rd_on_smp = 1'b1;
        pulse_start();
        repeat (90) @(posedge clk);
        #1; rd_on_smp = 1'b0;
        @(negedge clk);
        chk(diag_fail == 4'b0001 && irq && !int_n, "R11", "read/fault collision",
            diag_fail, 1);

        // R9: auto-repeat gap and repeated diagnostics
        @(posedge clk); #1;
        poll_en = 8'h81; diag_en = 4'b0001; adc_mode = 4'hF; src_dir = 4'b0011;
        bad_mask = 4'b0001;
        clear_and_check();
        @(posedge clk); #1; auto_rpt = 1'b1;
        pulse_start();
        repeat (200) @(posedge clk);
        @(negedge clk);
        chk(gap_meas == IDLE + 1, "R9", "idle gap", gap_meas, IDLE + 1);
        chk(rises[0] >= 2, "R9", "repeated sequences", rises[0], 2);
        chk(diag_fail == 4'b0001 && irq, "R9", "diag in auto mode", diag_fail, 1);
        @(posedge clk); #1; auto_rpt = 1'b0;
        repeat (120) @(posedge clk);
        @(negedge clk);
        r0 = rises[0];
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(rises[0] == r0 && wet_en == 0, "R9", "stops without repeat", rises[0], r0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule